// File: doc/BRIEF.md
# Stereo Mute and Silence Auto-Mute Controller

This block sits in the path of a stereo digital audio stream in which left and right samples arrive one at a time as channel frames. Each frame comes with a valid strobe and a channel flag. The block applies three kinds of muting to the stream:

- a master mute that silences both channels;
- a separate mute for each channel;
- an automatic mute that engages after a long run of silence.

Each frame leaves one cycle after it arrives. A frame on a muted channel leaves as zero. The block also reports, through registered flags, whether each channel is muted and whether the silence detector has fired.

The control bits are captured into an internal register by a load strobe. That register comes out of reset with the master mute set and every other bit clear, so nothing is heard until the master mute is cleared. The silence detector counts consecutive zero-valued channel frames. When the run reaches a parameterised length (2048 frames by default), both channels are muted. The first frame whose value is nonzero ends the automatic mute at once, and that frame is passed through.

Top module: `stereo_mute_ctrl`

## Requirements
- R1: While the master mute bit is set, every output frame carries a zero sample, and both `mute_left` and `mute_right` read 1.
- R2: After reset, the master mute is set and the left, right and auto-enable bits are clear. Both mute flags read 1 and `out_valid` reads 0 until frames arrive.
- R3: The left mute (`cfg_left`) zeroes only frames with `in_chan`=0 and raises only `mute_left`. The right mute (`cfg_right`) zeroes only frames with `in_chan`=1 and raises only `mute_right`.
- R4: With auto-mute enabled, the frame that completes a run of RUN_LEN consecutive zero frames (2048 by default, either channel) sets `auto_muted` and is reported as muted on both flags. After 2047 zero frames, `auto_muted` is still 0.
- R5: A valid frame with a nonzero sample clears `auto_muted` at once. That same frame is passed unchanged unless another mute applies to its channel.
- R6: The silence run restarts from zero after any nonzero frame. Clearing the auto-enable bit clears the run and, on the following cycle, clears `auto_muted`.
- R7: Each valid input frame appears on the outputs exactly one cycle later with the same channel flag. If no mute applies, the sample is unchanged. `out_valid` is 0 one cycle after a cycle with no valid input.
- R8: `mute_left` and `mute_right` change only one cycle after a valid frame. A change loaded into the control register takes effect on the next frame, not on the flags directly.
- R9: Cycles without a valid frame neither advance nor break the silence run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Loads the four control bits into the control register |
| cfg_master | input | 1 | Master mute request |
| cfg_left | input | 1 | Left channel mute request |
| cfg_right | input | 1 | Right channel mute request |
| cfg_auto | input | 1 | Auto-mute enable |
| in_valid | input | 1 | Input frame strobe |
| in_chan | input | 1 | Input channel flag, 0 left, 1 right |
| in_sample | input | SAMPLE_W | Input sample |
| out_valid | output | 1 | Output frame strobe |
| out_chan | output | 1 | Output channel flag |
| out_sample | output | SAMPLE_W | Output sample, zero when its channel is muted |
| mute_left | output | 1 | Left channel muted (registered) |
| mute_right | output | 1 | Right channel muted (registered) |
| auto_muted | output | 1 | Silence auto-mute active (registered) |

## Verification
Every result is due one edge after its cause:

- an output frame and its mute flags, one edge after the input frame is sampled;
- an auto-mute clear, one edge after the auto-enable bit is found clear;
- a control load, at the first frame after the loading edge.

The bench drives inputs on the falling edge. It advances a behavioural model of the same edge. On the next falling edge it compares every output, so each result is checked in exactly the cycle it is due. Directed checks at the 2047th and 2048th zero frames pin the run boundary.

// File: rtl/mute_pkg.sv
package mute_pkg;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    typedef struct packed {
        logic master;
        logic left;
        logic right;
        logic auto_en;
    } mute_cfg_t;

    localparam mute_cfg_t CFG_AT_RESET = '{master: 1'b1, left: 1'b0, right: 1'b0, auto_en: 1'b0};

    localparam int NUM_CH = 2;

    function automatic logic chan_request(mute_cfg_t c, int unsigned ch);
        return (ch == 0) ? c.left : c.right;
    endfunction

    function automatic logic chan_is_muted(mute_cfg_t c, int unsigned ch, logic silenced);
        return c.master | chan_request(c, ch) | silenced;
    endfunction

endpackage

// File: rtl/mute_cfg_reg.sv
module mute_cfg_reg
    import mute_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  mute_cfg_t cfg_d,
    output mute_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_AT_RESET;
        end else if (load) begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/mute_silence_det.sv
module mute_silence_det #(
    parameter int SAMPLE_W = 24,
    parameter int RUN_LEN  = 2048
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                frame_valid,
    input  logic [SAMPLE_W-1:0] frame_sample,
    output logic                silenced_next,
    output logic                silenced_q
);

    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_BEFORE = CNT_W'(RUN_LEN - 1);
    localparam logic [CNT_W-1:0] SAT_VALUE   = CNT_W'(RUN_LEN);

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_d;
    logic             frame_silent;

    assign frame_silent = (frame_sample == '0);

    always_comb begin
        run_d         = run_q;
        silenced_next = silenced_q;
        if (!enable) begin
            run_d         = '0;
            silenced_next = 1'b0;
        end else if (frame_valid) begin
            if (!frame_silent) begin
                run_d         = '0;
                silenced_next = 1'b0;
            end else begin
                if (run_q != SAT_VALUE) begin
                    run_d = run_q + 1'b1;
                end
                if (run_q == LAST_BEFORE) begin
                    silenced_next = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q      <= '0;
            silenced_q <= 1'b0;
        end else begin
            run_q      <= run_d;
            silenced_q <= silenced_next;
        end
    end

endmodule

// File: rtl/mute_gate.sv
module mute_gate
    import mute_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  mute_cfg_t           cfg,
    input  logic                silenced_next,
    input  logic                frame_valid,
    input  logic                frame_chan,
    input  logic [SAMPLE_W-1:0] frame_sample,
    output logic                out_valid,
    output logic                out_chan,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic [NUM_CH-1:0]   chan_muted_q
);

    logic [NUM_CH-1:0] chan_muted_d;
    logic              sel_muted;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        assign chan_muted_d[ch] = chan_is_muted(cfg, ch, silenced_next);

        always_ff @(posedge clk) begin
            if (rst) begin
                chan_muted_q[ch] <= CFG_AT_RESET.master;
            end else if (frame_valid) begin
                chan_muted_q[ch] <= chan_muted_d[ch];
            end
        end
    end

    assign sel_muted = chan_muted_d[frame_chan];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_chan   <= CH_LEFT;
            out_sample <= '0;
        end else begin
            out_valid <= frame_valid;
            if (frame_valid) begin
                out_chan   <= frame_chan;
                out_sample <= sel_muted ? '0 : frame_sample;
            end
        end
    end

endmodule

// File: rtl/stereo_mute_ctrl.sv
module stereo_mute_ctrl
    import mute_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int RUN_LEN  = 2048
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_load,
    input  logic                cfg_master,
    input  logic                cfg_left,
    input  logic                cfg_right,
    input  logic                cfg_auto,
    input  logic                in_valid,
    input  logic                in_chan,
    input  logic [SAMPLE_W-1:0] in_sample,
    output logic                out_valid,
    output logic                out_chan,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic                mute_left,
    output logic                mute_right,
    output logic                auto_muted
);

    mute_cfg_t         cfg_d;
    mute_cfg_t         cfg_q;
    logic              silenced_next;
    logic              silenced_q;
    logic [NUM_CH-1:0] muted_flags;

    assign cfg_d = '{master: cfg_master, left: cfg_left, right: cfg_right, auto_en: cfg_auto};

    mute_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .load  (cfg_load),
        .cfg_d (cfg_d),
        .cfg_q (cfg_q)
    );

    mute_silence_det #(
        .SAMPLE_W (SAMPLE_W),
        .RUN_LEN  (RUN_LEN)
    ) u_det (
        .clk           (clk),
        .rst           (rst),
        .enable        (cfg_q.auto_en),
        .frame_valid   (in_valid),
        .frame_sample  (in_sample),
        .silenced_next (silenced_next),
        .silenced_q    (silenced_q)
    );

    mute_gate #(
        .SAMPLE_W (SAMPLE_W)
    ) u_gate (
        .clk           (clk),
        .rst           (rst),
        .cfg           (cfg_q),
        .silenced_next (silenced_next),
        .frame_valid   (in_valid),
        .frame_chan    (in_chan),
        .frame_sample  (in_sample),
        .out_valid     (out_valid),
        .out_chan      (out_chan),
        .out_sample    (out_sample),
        .chan_muted_q  (muted_flags)
    );

    assign mute_left  = muted_flags[CH_LEFT];
    assign mute_right = muted_flags[CH_RIGHT];
    assign auto_muted = silenced_q;

endmodule

// File: rtl/stereo_mute_chk.sv
module stereo_mute_chk #(
    parameter int SAMPLE_W = 24
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_chan,
    input logic [SAMPLE_W-1:0] in_sample,
    input logic                out_valid,
    input logic                out_chan,
    input logic [SAMPLE_W-1:0] out_sample,
    input logic                mute_left,
    input logic                mute_right,
    input logic                auto_muted
);

    a_r2_reset_state: assert property (@(posedge clk)
        rst |=> (mute_left && mute_right && !out_valid && !auto_muted));

    a_r1_left_zeroed: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_chan && mute_left) |-> (out_sample == '0));

    a_r3_right_zeroed: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_chan && mute_right) |-> (out_sample == '0));

    a_r5_nonzero_unmutes: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sample != '0) |=> !auto_muted);

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid && out_chan == $past(in_chan)));

    a_r7_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r7_pass_left: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_chan && !mute_left) |-> (out_sample == $past(in_sample)));

    a_r8_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(mute_left) && $stable(mute_right)));

    a_r4_auto_implies_flags: assert property (@(posedge clk) disable iff (rst)
        (auto_muted && $rose(auto_muted)) |-> (mute_left && mute_right && $past(in_valid)));

endmodule

bind stereo_mute_ctrl stereo_mute_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_chan    (in_chan),
    .in_sample  (in_sample),
    .out_valid  (out_valid),
    .out_chan   (out_chan),
    .out_sample (out_sample),
    .mute_left  (mute_left),
    .mute_right (mute_right),
    .auto_muted (auto_muted)
);

// File: tb/tb_stereo_mute_ctrl.sv
`timescale 1ns/1ps
module tb_stereo_mute_ctrl;

    localparam int SW   = 24;
    localparam int RUNL = 2048;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_load = 1'b0, cfg_master = 1'b0, cfg_left = 1'b0, cfg_right = 1'b0, cfg_auto = 1'b0;
    logic in_valid = 1'b0, in_chan = 1'b0;
    logic [SW-1:0] in_sample = '0;
    logic out_valid, out_chan, mute_left, mute_right, auto_muted;
    logic [SW-1:0] out_sample;

    always #2.5 clk = ~clk;

    stereo_mute_ctrl #(.SAMPLE_W(SW), .RUN_LEN(RUNL)) dut (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_master(cfg_master),
        .cfg_left(cfg_left), .cfg_right(cfg_right), .cfg_auto(cfg_auto),
        .in_valid(in_valid), .in_chan(in_chan), .in_sample(in_sample),
        .out_valid(out_valid), .out_chan(out_chan), .out_sample(out_sample),
        .mute_left(mute_left), .mute_right(mute_right), .auto_muted(auto_muted)
    );

    int checks = 0;
    int failures = 0;
    string tag = "R2";

    // behavioural reference state
    bit m_master = 1, m_l = 0, m_r = 0, m_auto = 0;
    int m_run = 0;
    bit m_am = 0;
    bit e_valid = 0, e_chan = 0, e_ml = 1, e_mr = 1;
    logic [SW-1:0] e_sample = '0;

    task automatic check(string t, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(tag, "out_valid", out_valid, e_valid);
        check(tag, "mute_left", mute_left, e_ml);
        check(tag, "mute_right", mute_right, e_mr);
        check(tag, "auto_muted", auto_muted, m_am);
        if (e_valid) begin
            check(tag, "out_chan", out_chan, e_chan);
            check(tag, "out_sample", out_sample, e_sample);
        end
    endtask

    // one cycle: drive at falling edge, predict, clock, compare
    task automatic step(bit v, bit ch, logic [SW-1:0] s, bit ld = 0,
                        bit cm = 0, bit cl = 0, bit cr = 0, bit ca = 0);
        bit am_n;
        bit mu;
        in_valid = v; in_chan = ch; in_sample = s;
        cfg_load = ld; cfg_master = cm; cfg_left = cl; cfg_right = cr; cfg_auto = ca;
        am_n = m_am;
        if (!m_auto) begin
            m_run = 0; am_n = 0;
        end else if (v) begin
            if (s != 0) begin
                m_run = 0; am_n = 0;
            end else begin
                if (m_run < RUNL) m_run++;
                if (m_run >= RUNL) am_n = 1;
            end
        end
        e_valid = v;
        if (v) begin
            mu = m_master | (ch ? m_r : m_l) | am_n;
            e_chan = ch;
            e_sample = mu ? '0 : s;
            e_ml = m_master | m_l | am_n;
            e_mr = m_master | m_r | am_n;
        end
        m_am = am_n;
        if (ld) begin
            m_master = cm; m_l = cl; m_r = cr; m_auto = ca;
        end
        @(posedge clk);
        @(negedge clk);
        cfg_load = 0;
        compare_all();
    endtask

    function automatic logic [SW-1:0] pat(int i);
        return SW'((i * 40503 + 12345) % (1 << SW)) | SW'(1);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R2: state right after reset
        tag = "R2";
        check("R2", "mute_left after reset", mute_left, 1);
        check("R2", "mute_right after reset", mute_right, 1);
        check("R2", "out_valid after reset", out_valid, 0);
        check("R2", "auto_muted after reset", auto_muted, 0);
        for (int i = 0; i < 6; i++) step(1, i[0], pat(i));
        check("R2", "sample zero before unmute", out_sample, 0);

        // R7: plain passthrough, mixed with idle cycles
        tag = "R7";
        step(0, 0, '0, 1, 0, 0, 0, 0);
        for (int i = 0; i < 20; i++) begin
            step(1, i[0], pat(i + 100));
            if (i % 3 == 0) step(0, 0, pat(i));
        end
        step(1, 1, 24'hABCDEF);
        check("R7", "right passthrough", out_sample, 24'hABCDEF);

        // R8: control load without frames leaves flags alone
        tag = "R8";
        step(0, 0, '0, 1, 0, 1, 0, 0);
        check("R8", "mute_left before next frame", mute_left, 0);
        step(0, 0, '0);
        check("R8", "mute_left still idle", mute_left, 0);

        // R3: left only, then right only
        tag = "R3";
        for (int i = 0; i < 8; i++) step(1, i[0], pat(i + 200));
        step(1, 0, 24'h000123);
        check("R3", "left zeroed", out_sample, 0);
        step(1, 1, 24'h000456);
        check("R3", "right untouched", out_sample, 24'h000456);
        check("R3", "mute_right low", mute_right, 0);
        step(0, 0, '0, 1, 0, 0, 1, 0);
        for (int i = 0; i < 8; i++) step(1, i[0], pat(i + 300));
        step(1, 0, 24'h000777);
        check("R3", "left passes under right mute", out_sample, 24'h000777);

        // R1: master mute
        tag = "R1";
        step(0, 0, '0, 1, 1, 0, 0, 0);
        for (int i = 0; i < 8; i++) step(1, i[0], pat(i + 400));
        check("R1", "mute_left under master", mute_left, 1);
        check("R1", "mute_right under master", mute_right, 1);

        // R4 + R9: silence run with idle gaps
        tag = "R4";
        step(0, 0, '0, 1, 0, 0, 0, 1);
        for (int i = 0; i < RUNL - 1; i++) begin
            step(1, i[0], '0);
            if (i % 97 == 0) step(0, 0, pat(i));
        end
        check("R4", "not muted after 2047 zero frames", auto_muted, 0);
        check("R9", "idle cycles kept the run", mute_left, 0);
        step(1, 1, '0);
        check("R4", "muted at 2048th zero frame", auto_muted, 1);
        check("R4", "left flag on auto", mute_left, 1);
        for (int i = 0; i < 10; i++) step(1, i[0], '0);

        // R5: a nonzero frame unmutes and passes
        tag = "R5";
        step(1, 0, 24'h00BEEF);
        check("R5", "auto cleared", auto_muted, 0);
        check("R5", "nonzero frame passes", out_sample, 24'h00BEEF);

        // R6: run restarts after nonzero, disable clears
        tag = "R6";
        for (int i = 0; i < 2000; i++) step(1, i[0], '0);
        step(1, 1, 24'h000001);
        for (int i = 0; i < RUNL - 1; i++) step(1, i[0], '0);
        check("R6", "run restarted after nonzero", auto_muted, 0);
        step(1, 0, '0);
        check("R6", "muted after full new run", auto_muted, 1);
        step(0, 0, '0, 1, 0, 0, 0, 0);
        step(0, 0, '0);
        check("R6", "disable clears auto", auto_muted, 0);
        step(1, 0, 24'h000042);
        check("R6", "output after disable", out_sample, 24'h000042);

        // R6: disable mid-run then re-enable starts fresh
        step(0, 0, '0, 1, 0, 0, 0, 1);
        for (int i = 0; i < 1500; i++) step(1, i[0], '0);
        step(0, 0, '0, 1, 0, 0, 0, 0);
        step(0, 0, '0, 1, 0, 0, 0, 1);
        for (int i = 0; i < 1000; i++) step(1, i[0], '0);
        check("R6", "run cleared by disable", auto_muted, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule